// File: doc/BRIEF.md
# CCD Sensor Drive Timing Generator

This block derives every digital drive signal of an interline progressive-scan CCD from a single master clock. It counts clocks within a line and lines within a frame, and decodes from those counts the line and frame syncs, the complementary horizontal shift clocks with their reset-gate pulse, the three vertical transfer phases, the readout pulses that move photodiode charge into the vertical register, and the substrate pulses of the electronic shutter. All outputs are registered and change one clock after the counter state they decode. Level translation and the vertical driver stage sit outside the block.

Three scan modes are supported. Full scan moves one row per line through the whole frame. Two centre-crop modes keep a short frame. Right after readout, a frame-shift burst of continuous vertical stepping removes the unwanted upper rows. Then the kept rows are moved one per line. Finally, a sweep burst dumps the lower rows. The mode and the shutter line count are captured only when a frame begins, so a frame never mixes two settings.

Top module: `ccd_timing_gen`

## Requirements
- R1: While reset is applied, and in the first clock after it is released, every output is low.
- R2: A line lasts LINE_CLKS clocks. A frame has FULL_LINES lines for mode code 0 or 3, CROP_A_LINES lines for code 1, and CROP_B_LINES lines for code 2. `hd_o` is high for the first HD_CLKS clocks of every line. `vd_o` is high throughout line 0 of every frame.
- R3: The first frame starts at the first clock edge after reset is released. Its `vd_o` appears one clock later. Until then the vertical phases and `sub_o` stay low.
- R4: Once running, the phases {v1,v2,v3} take only the six transfer step patterns. By step index 0 to 5 these are 100, 110, 010, 011, 001, 101. The idle pattern is 100.
- R5: On every line except line 0 and the burst lines, a transfer runs from clock 0 of the line. It walks the six steps in order, each held STEP_CLKS clocks, and restarts from step 0 at each such line.
- R6: In a crop mode the phases step continuously, each step lasting STEP_CLKS clocks, through the shift lines 1 to SHIFT. They do the same through the sweep lines, which start at line 1+SHIFT+KEEP and last SWEEP lines. SHIFT, KEEP and SWEEP are the CROP_A_* values for code 1 and the CROP_B_* values for code 2.
- R7: `rd_v2_o` and `rd_v3_o` pulse together during line 0, on clocks RD_START to RD_START+RD_CLKS-1, and at no other time.
- R8: `sub_o` is high on clocks SUB_START to SUB_START+SUB_CLKS-1 of line L exactly when L is at least 1 and L plus the captured shutter count is below the frame length. A count at or above the frame length less one gives no substrate pulse.
- R9: In the blanking part of a line (clock below HBLANK_CLKS), `h1_o` is 1 and `h2_o` and `rg_o` are 0. After that, `h1_o` and `rg_o` are high on even clocks and `h2_o` on odd clocks.
- R10: `mode_i` and `shut_i` take effect only at a frame start. A change mid-frame alters nothing until the next line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Scan mode: 0/3 full, 1 crop A, 2 crop B |
| shut_i | input | SHUT_W | Shutter count in lines before readout |
| hd_o | output | 1 | Line sync |
| vd_o | output | 1 | Frame sync |
| h1_o | output | 1 | Horizontal shift clock, phase 1 |
| h2_o | output | 1 | Horizontal shift clock, phase 2 |
| rg_o | output | 1 | Reset-gate pulse |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| v3_o | output | 1 | Vertical phase 3 |
| rd_v2_o | output | 1 | Readout pulse carried on phase 2 |
| rd_v3_o | output | 1 | Readout pulse carried on phase 3 |
| sub_o | output | 1 | Substrate shutter pulse |

## Verification
The embedded checks take for granted that the burst and kept-row counts of each crop mode fit inside its frame. They also assume the six-step line transfer, the readout window and the substrate window all end inside the blanking part of a line, and that STEP_CLKS is at least 2. The bench keeps to these by using one fixed set of reduced parameters that satisfies them. Its random stimulus only changes the mode and shutter inputs, including in the middle of frames and with codes 3 and counts beyond the frame length. Line and burst geometry therefore always stays legal, while the capture-at-frame-start behaviour is exercised hard.

// File: rtl/ccdtg_pkg.sv
// Shared types for the CCD drive timing generator.
// Assumes the vertical register is a three-phase device stepped in six states.
package ccdtg_pkg;

    typedef enum logic [1:0] {
        SCAN_FULL     = 2'd0,
        SCAN_CROP_A   = 2'd1,
        SCAN_CROP_B   = 2'd2,
        SCAN_FULL_ALT = 2'd3
    } scan_mode_e;

    localparam int PHASE_STEPS = 6;

    // Phase pattern {v1,v2,v3} for step index 0..5 of one row transfer.
    function automatic logic [2:0] phase_pattern(input logic [2:0] idx);
        case (idx)
            3'd0:    return 3'b100;
            3'd1:    return 3'b110;
            3'd2:    return 3'b010;
            3'd3:    return 3'b011;
            3'd4:    return 3'b001;
            3'd5:    return 3'b101;
            default: return 3'b100;
        endcase
    endfunction

endpackage

// File: rtl/ccdtg_frame_ctr.sv
// Pixel and line counters with per-frame capture of mode and shutter count.
// Assumes the crop frame lengths do not exceed FULL_LINES.
module ccdtg_frame_ctr
    import ccdtg_pkg::*;
#(
    parameter int LINE_CLKS    = 944,
    parameter int FULL_LINES   = 625,
    parameter int CROP_A_LINES = 312,
    parameter int CROP_B_LINES = 156,
    parameter int SHUT_W       = 10,
    parameter int PIX_W        = $clog2(LINE_CLKS),
    parameter int LIN_W        = $clog2(FULL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [SHUT_W-1:0] shut_i,
    output logic              running_o,
    output logic [PIX_W-1:0]  pcnt_o,
    output logic [LIN_W-1:0]  lcnt_o,
    output scan_mode_e        mode_o,
    output logic [SHUT_W-1:0] shut_o,
    output logic [LIN_W:0]    flines_o
);

    logic              running_q;
    logic [PIX_W-1:0]  pcnt_q;
    logic [LIN_W-1:0]  lcnt_q;
    scan_mode_e        mode_q;
    logic [SHUT_W-1:0] shut_q;
    logic [LIN_W:0]    flines;
    logic              last_pix;
    logic              frame_start;

    // Frame length chosen by the captured mode.
    always_comb begin
        case (mode_q)
            SCAN_CROP_A: flines = (LIN_W+1)'(CROP_A_LINES);
            SCAN_CROP_B: flines = (LIN_W+1)'(CROP_B_LINES);
            default:     flines = (LIN_W+1)'(FULL_LINES);
        endcase
    end

    // Line end and frame start events.
    always_comb begin
        last_pix    = (pcnt_q == PIX_W'(LINE_CLKS - 1));
        frame_start = !running_q || (last_pix && (({1'b0, lcnt_q} + 1'b1) == flines));
    end

    // Counter advance and frame-start capture of the control inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            pcnt_q    <= '0;
            lcnt_q    <= '0;
            mode_q    <= SCAN_FULL;
            shut_q    <= '0;
        end else if (frame_start) begin
            running_q <= 1'b1;
            pcnt_q    <= '0;
            lcnt_q    <= '0;
            mode_q    <= scan_mode_e'(mode_i);
            shut_q    <= shut_i;
        end else if (last_pix) begin
            pcnt_q    <= '0;
            lcnt_q    <= lcnt_q + 1'b1;
        end else begin
            pcnt_q    <= pcnt_q + 1'b1;
        end
    end

    assign running_o = running_q;
    assign pcnt_o    = pcnt_q;
    assign lcnt_o    = lcnt_q;
    assign mode_o    = mode_q;
    assign shut_o    = shut_q;
    assign flines_o  = flines;

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !frame_start) |=> ($stable(mode_q) && $stable(shut_q)));

    assert_line_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> ({1'b0, lcnt_q} < flines));

    assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && last_pix) |=> (pcnt_q == '0));

endmodule

// File: rtl/ccdtg_vseq.sv
// Six-step vertical phase sequencer; advances one step every STEP_CLKS clocks
// while run_i is high, and returns to step 0 when run_i drops or restart_i is set.
// Assumes STEP_CLKS >= 2.
module ccdtg_vseq #(
    parameter int STEP_CLKS = 16,
    parameter int STEP_W    = $clog2(STEP_CLKS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       restart_i,
    output logic [2:0] idx_o
);

    localparam int LAST_IDX = ccdtg_pkg::PHASE_STEPS - 1;

    logic [STEP_W-1:0] step_q, step_eff;
    logic [2:0]        idx_q, idx_eff;

    // Effective position this clock, with restart forcing step 0.
    always_comb begin
        step_eff = restart_i ? '0 : step_q;
        idx_eff  = restart_i ? 3'd0 : idx_q;
    end

    // Step timer and index advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            step_q <= '0;
            idx_q  <= 3'd0;
        end else if (step_eff == STEP_W'(STEP_CLKS - 1)) begin
            step_q <= '0;
            idx_q  <= (idx_eff == 3'(LAST_IDX)) ? 3'd0 : idx_eff + 3'd1;
        end else begin
            step_q <= step_eff + 1'b1;
            idx_q  <= idx_eff;
        end
    end

    assign idx_o = idx_eff;

    assert_step_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && step_q != STEP_W'(STEP_CLKS - 1)) |=> $stable(idx_q));

    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (idx_q == 3'd0 && step_q == '0));

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= 3'(LAST_IDX));

endmodule

// File: rtl/ccdtg_hgen.sv
// Horizontal shift clocks and reset-gate pulse decoded from the pixel count.
// Assumes HBLANK_CLKS is below LINE_CLKS; all outputs low until running.
module ccdtg_hgen #(
    parameter int HBLANK_CLKS = 160,
    parameter int PIX_W       = 10
) (
    input  logic             running_i,
    input  logic [PIX_W-1:0] pcnt_i,
    output logic             h1_o,
    output logic             h2_o,
    output logic             rg_o
);

    // Hold in blanking, toggle every clock in the active part.
    always_comb begin
        if (!running_i) begin
            h1_o = 1'b0;
            h2_o = 1'b0;
            rg_o = 1'b0;
        end else if (pcnt_i < PIX_W'(HBLANK_CLKS)) begin
            h1_o = 1'b1;
            h2_o = 1'b0;
            rg_o = 1'b0;
        end else begin
            h1_o = ~pcnt_i[0];
            h2_o =  pcnt_i[0];
            rg_o = ~pcnt_i[0];
        end
    end

endmodule

// File: rtl/ccd_timing_gen.sv
// CCD drive timing generator top: decodes syncs, vertical transfer windows,
// crop-mode bursts, readout and shutter pulses from the frame counters and
// registers every output. Assumes the transfer, readout and substrate windows
// lie inside the blanking part of a line and crop geometry fits its frame.
module ccd_timing_gen
    import ccdtg_pkg::*;
#(
    parameter int LINE_CLKS    = 944,
    parameter int HBLANK_CLKS  = 160,
    parameter int HD_CLKS      = 64,
    parameter int STEP_CLKS    = 16,
    parameter int RD_START     = 32,
    parameter int RD_CLKS      = 64,
    parameter int SUB_START    = 110,
    parameter int SUB_CLKS     = 32,
    parameter int FULL_LINES   = 625,
    parameter int CROP_A_LINES = 312,
    parameter int CROP_A_SHIFT = 17,
    parameter int CROP_A_KEEP  = 264,
    parameter int CROP_A_SWEEP = 20,
    parameter int CROP_B_LINES = 156,
    parameter int CROP_B_SHIFT = 26,
    parameter int CROP_B_KEEP  = 88,
    parameter int CROP_B_SWEEP = 31,
    parameter int SHUT_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [SHUT_W-1:0] shut_i,
    output logic              hd_o,
    output logic              vd_o,
    output logic              h1_o,
    output logic              h2_o,
    output logic              rg_o,
    output logic              v1_o,
    output logic              v2_o,
    output logic              v3_o,
    output logic              rd_v2_o,
    output logic              rd_v3_o,
    output logic              sub_o
);

    localparam int PIX_W     = $clog2(LINE_CLKS);
    localparam int LIN_W     = $clog2(FULL_LINES);
    localparam int XFER_CLKS = PHASE_STEPS * STEP_CLKS;
    localparam int A_SW_LO   = 1 + CROP_A_SHIFT + CROP_A_KEEP;
    localparam int B_SW_LO   = 1 + CROP_B_SHIFT + CROP_B_KEEP;

    logic              running;
    logic [PIX_W-1:0]  pcnt;
    logic [LIN_W-1:0]  lcnt;
    scan_mode_e        mode_q;
    logic [SHUT_W-1:0] shut_q;
    logic [LIN_W:0]    flines;
    logic [2:0]        step_idx;
    logic              burst_line, seq_run, seq_restart;
    logic              hd_d, vd_d, rd_d, sub_d, h1_d, h2_d, rg_d;
    logic [2:0]        vpat_d;
    int                line_i, pix_i;

    ccdtg_frame_ctr #(
        .LINE_CLKS(LINE_CLKS), .FULL_LINES(FULL_LINES),
        .CROP_A_LINES(CROP_A_LINES), .CROP_B_LINES(CROP_B_LINES),
        .SHUT_W(SHUT_W), .PIX_W(PIX_W), .LIN_W(LIN_W)
    ) frame_ctr_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .shut_i(shut_i),
        .running_o(running), .pcnt_o(pcnt), .lcnt_o(lcnt),
        .mode_o(mode_q), .shut_o(shut_q), .flines_o(flines)
    );

    ccdtg_vseq #(.STEP_CLKS(STEP_CLKS)) vseq_i (
        .clk(clk), .rst_n(rst_n), .run_i(seq_run),
        .restart_i(seq_restart), .idx_o(step_idx)
    );

    ccdtg_hgen #(.HBLANK_CLKS(HBLANK_CLKS), .PIX_W(PIX_W)) hgen_i (
        .running_i(running), .pcnt_i(pcnt),
        .h1_o(h1_d), .h2_o(h2_d), .rg_o(rg_d)
    );

    // Burst-line membership for the captured crop mode.
    always_comb begin
        line_i = int'(lcnt);
        pix_i  = int'(pcnt);
        case (mode_q)
            SCAN_CROP_A: burst_line =
                (line_i >= 1 && line_i < 1 + CROP_A_SHIFT) ||
                (line_i >= A_SW_LO && line_i < A_SW_LO + CROP_A_SWEEP);
            SCAN_CROP_B: burst_line =
                (line_i >= 1 && line_i < 1 + CROP_B_SHIFT) ||
                (line_i >= B_SW_LO && line_i < B_SW_LO + CROP_B_SWEEP);
            default:     burst_line = 1'b0;
        endcase
    end

    // Vertical sequencer control: continuous in bursts, one transfer per normal line.
    always_comb begin
        seq_run     = running && (line_i != 0) && (burst_line || pix_i < XFER_CLKS);
        seq_restart = running && (pix_i == 0) && !burst_line;
    end

    // Sync, readout, shutter and phase decode ahead of the output register.
    always_comb begin
        hd_d   = running && (pix_i < HD_CLKS);
        vd_d   = running && (line_i == 0);
        rd_d   = running && (line_i == 0) &&
                 (pix_i >= RD_START) && (pix_i < RD_START + RD_CLKS);
        sub_d  = running && (line_i != 0) &&
                 (line_i + int'(shut_q) < int'(flines)) &&
                 (pix_i >= SUB_START) && (pix_i < SUB_START + SUB_CLKS);
        vpat_d = !running ? 3'b000 : phase_pattern(seq_run ? step_idx : 3'd0);
    end

    // Output register for glitch-free drive signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {hd_o, vd_o, h1_o, h2_o, rg_o}   <= '0;
            {v1_o, v2_o, v3_o}               <= '0;
            {rd_v2_o, rd_v3_o, sub_o}        <= '0;
        end else begin
            {hd_o, vd_o, h1_o, h2_o, rg_o}   <= {hd_d, vd_d, h1_d, h2_d, rg_d};
            {v1_o, v2_o, v3_o}               <= vpat_d;
            {rd_v2_o, rd_v3_o, sub_o}        <= {rd_d, rd_d, sub_d};
        end
    end

    assert_prestart_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> ({v1_o, v2_o, v3_o} == 3'b000 && !sub_o && !vd_o));

    assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($countones({v1_o, v2_o, v3_o}) inside {1, 2}));

    assert_readout_in_vd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_v2_o || rd_v3_o) |-> (vd_o && rd_v2_o && rd_v3_o && !sub_o));

    assert_sub_outside_vd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sub_o |-> !vd_o);

    assert_hclk_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (h1_o != h2_o));

endmodule

// File: tb/ccd_timing_gen_tb.sv
// Self-checking bench: reduced geometry, cycle model from the requirements,
// directed frames plus seeded random mode/shutter changes.
module ccd_timing_gen_tb_top;

    localparam int LINE = 64, HBL = 24, HDC = 8, STEP = 2;
    localparam int RDS = 4, RDC = 8, SBS = 16, SBC = 4;
    localparam int FULL = 20, AL = 12, AS = 2, AK = 5, AW = 3;
    localparam int BL = 8, BS = 1, BK = 2, BW = 2, SW = 5;
    localparam int MAX_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [SW-1:0] shut_i = '0;
    logic hd_o, vd_o, h1_o, h2_o, rg_o, v1_o, v2_o, v3_o, rd_v2_o, rd_v3_o, sub_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Model state: running flag, counters, captured settings, sequencer.
    bit m_run;
    int m_p, m_l, m_mode, m_shut, m_step, m_idx;

    always #2 clk = ~clk;

    ccd_timing_gen #(
        .LINE_CLKS(LINE), .HBLANK_CLKS(HBL), .HD_CLKS(HDC), .STEP_CLKS(STEP),
        .RD_START(RDS), .RD_CLKS(RDC), .SUB_START(SBS), .SUB_CLKS(SBC),
        .FULL_LINES(FULL), .CROP_A_LINES(AL), .CROP_A_SHIFT(AS),
        .CROP_A_KEEP(AK), .CROP_A_SWEEP(AW), .CROP_B_LINES(BL),
        .CROP_B_SHIFT(BS), .CROP_B_KEEP(BK), .CROP_B_SWEEP(BW), .SHUT_W(SW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .shut_i(shut_i),
        .hd_o(hd_o), .vd_o(vd_o), .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o),
        .v1_o(v1_o), .v2_o(v2_o), .v3_o(v3_o),
        .rd_v2_o(rd_v2_o), .rd_v3_o(rd_v3_o), .sub_o(sub_o)
    );

    function automatic int flines_of(int md);
        return (md == 1) ? AL : (md == 2) ? BL : FULL;
    endfunction

    function automatic bit burst_of(int md, int l);
        if (md == 1) return (l >= 1 && l < 1 + AS) || (l >= 1 + AS + AK && l < 1 + AS + AK + AW);
        if (md == 2) return (l >= 1 && l < 1 + BS) || (l >= 1 + BS + BK && l < 1 + BS + BK + BW);
        return 1'b0;
    endfunction

    function automatic logic [2:0] pat(int i);
        case (i)
            0: return 3'b100; 1: return 3'b110; 2: return 3'b010;
            3: return 3'b011; 4: return 3'b001; default: return 3'b101;
        endcase
    endfunction

    function automatic bit seq_run_of(int md, int l, int p);
        return (l != 0) && (burst_of(md, l) || p < 6 * STEP);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (line %0d clk %0d mode %0d)",
                     tag, act, exp, m_l, m_p, m_mode);
        end
    endtask

    // One clock: compare outputs at the negedge, then advance the model.
    task automatic cycle();
        int ridx, rstep;
        bit run, rst_now;
        @(negedge clk);
        rst_now = !rst_n;
        if (rst_now || !m_run) begin
            check("R1/R3 idle", {hd_o, vd_o, h1_o, h2_o, rg_o, v1_o, v2_o, v3_o, rd_v2_o, rd_v3_o, sub_o}, 0);
        end else begin
            run   = seq_run_of(m_mode, m_l, m_p);
            ridx  = (m_p == 0 && !burst_of(m_mode, m_l)) ? 0 : m_idx;
            rstep = (m_p == 0 && !burst_of(m_mode, m_l)) ? 0 : m_step;
            check("R2 sync", {hd_o, vd_o}, {m_p < HDC, m_l == 0});
            check(burst_of(m_mode, m_l) ? "R6 burst phases" : "R4/R5 phases",
                  {v1_o, v2_o, v3_o}, run ? pat(ridx) : 3'b100);
            check("R7 readout", {rd_v2_o, rd_v3_o},
                  (m_l == 0 && m_p >= RDS && m_p < RDS + RDC) ? 2'b11 : 2'b00);
            check("R8/R10 substrate", sub_o,
                  m_l != 0 && (m_l + m_shut < flines_of(m_mode)) && m_p >= SBS && m_p < SBS + SBC);
            check("R9 hclk", {h1_o, h2_o, rg_o},
                  (m_p < HBL) ? 3'b100 : {m_p % 2 == 0, m_p % 2 == 1, m_p % 2 == 0});
            if (run) begin
                if (rstep == STEP - 1) begin m_step = 0; m_idx = (ridx + 1) % 6; end
                else begin m_step = rstep + 1; m_idx = ridx; end
            end else begin
                m_step = 0; m_idx = 0;
            end
        end
        // Counter advance with frame-start capture (R10).
        if (rst_now) begin
            m_run = 0; m_p = 0; m_l = 0; m_step = 0; m_idx = 0;
        end else if (!m_run || (m_p == LINE - 1 && m_l == flines_of(m_mode) - 1)) begin
            m_run = 1; m_p = 0; m_l = 0;
            m_mode = (int'(mode_i) == 3) ? 0 : int'(mode_i);
            m_shut = int'(shut_i);
            m_step = 0; m_idx = 0;
        end else if (m_p == LINE - 1) begin
            m_p = 0; m_l++;
        end else begin
            m_p++;
        end
    endtask

    task automatic run_cycles(int n, int chg_per_k);
        for (int i = 0; i < n; i++) begin
            cycle();
            if (chg_per_k != 0 && ($urandom % 1000) < chg_per_k) begin
                mode_i = 2'($urandom % 4);
                shut_i = SW'($urandom % (FULL + 4));
            end
        end
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd7151);
        m_run = 0; m_p = 0; m_l = 0; m_mode = 0; m_shut = 0; m_step = 0; m_idx = 0;
        // R1: reset state.
        run_cycles(4, 0);
        rst_n = 1'b1;
        // R2/R5/R8: full scan, shutter 0 (pulses on every line but 0).
        run_cycles(2 * FULL * LINE + 10, 0);
        // R6: crop A with a mid-size shutter count, changed mid-frame (R10).
        mode_i = 2'd1; shut_i = 5'd3;
        run_cycles(LINE * 7, 0);
        shut_i = 5'd9;
        run_cycles(3 * AL * LINE, 0);
        // R6/R8: crop B with count beyond frame length, so no substrate pulse.
        mode_i = 2'd2; shut_i = 5'd30;
        run_cycles(3 * BL * LINE, 0);
        // R2: code 3 behaves as full scan; boundary count frame-1.
        mode_i = 2'd3; shut_i = 5'(FULL - 1);
        run_cycles(FULL * LINE + 50, 0);
        // R1/R3: reset in the middle of a frame, then restart.
        rst_n = 1'b0;
        run_cycles(3, 0);
        mode_i = 2'd1; shut_i = 5'd0;
        rst_n = 1'b1;
        run_cycles(2 * AL * LINE, 0);
        // Random mode and shutter changes at arbitrary clocks.
        run_cycles(60000, 3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule